// File: doc/BRIEF.md
# Three-Port Register File with Constant-Zero Entry

This block is the operand store of a small RISC datapath. It keeps thirty-two 32-bit general-purpose registers. In each clock cycle it can supply two source operands through two independent read ports and accept one result through a single write port.

Both read ports are purely combinational. An index presented on a read port yields that register's contents in the same cycle, with no clock in between. The write port commits on the rising clock edge, and only when its enable is high. Entry 0 is not storage: it always reads as zero and throws away anything written to it, so the datapath can use it as a constant-zero operand. A synchronous, active-low reset clears every register.

A build parameter, `RD_ORDER`, decides what a read returns when it names the register that is being written in the same cycle. With the default `READ_OLD`, the read returns the value held before the edge. With `READ_NEW`, the incoming write data is forwarded to the read port.

Top module: `regfile_3p`

## Requirements
- R1: When `rst_n` is low at a rising edge of `clk`, all 31 storage registers become zero, and this takes precedence over a write presented in the same cycle.
- R2: When `wr_en` is high at a rising edge, `rst_n` is high and `wr_idx` is non-zero, register `wr_idx` takes `wr_data`. From that edge on, both read ports return that value for that index.
- R3: When `wr_en` is low at a rising edge, no register changes, whatever `wr_idx` and `wr_data` hold.
- R4: A read of index 0 returns 32'h0 on either port at all times.
- R5: A write with `wr_en` high and `wr_idx` equal to 0 changes no register, and index 0 still reads zero afterwards.
- R6: The two read ports are combinational and independent. Each returns the register named by its own index in the same cycle that index is applied, and both may name different registers at once.
- R7: A write changes only the addressed register. Every other register keeps its value.
- R8: When a read index equals a non-zero `wr_idx` while `wr_en` and `rst_n` are high, the port returns the pre-edge value if `RD_ORDER` is `READ_OLD` (encoding 0, the default). It returns `wr_data` if `RD_ORDER` is `READ_NEW` (encoding 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_a_idx | input | 5 | Register index for read port A |
| rd_a_data | output | 32 | Contents of the register named on port A |
| rd_b_idx | input | 5 | Register index for read port B |
| rd_b_data | output | 32 | Contents of the register named on port B |
| wr_en | input | 1 | Write enable for the write port |
| wr_idx | input | 5 | Destination register index |
| wr_data | input | 32 | Value to be written |

## Verification
A write and a read of the same register can fall in the same cycle. The write commits at the edge, while the read is combinational before that edge. The bench provokes this overlap deliberately while filling the file, with read port A pointed at the destination of every write. Random traffic makes it happen again by chance.

Two copies of the block, one per `RD_ORDER` setting, receive identical stimulus. The scoreboard expects the pre-edge model value from the first copy and the write data from the second. It then checks the following cycle, where both copies must agree on the stored value. Writes aimed at index 0 and simultaneous reset-plus-write are overlaps of the same kind, and are judged against the model in the same way.

// File: rtl/regfile_pkg.sv
// Package regfile_pkg
// Purpose : shared defaults and the read-during-write ordering type for the
//           three-port register file.
// Assumes : nothing; pure declarations.
package regfile_pkg;

    localparam int REG_COUNT = 32;
    localparam int WORD_BITS = 32;

    // Value a read port returns when it names the register being written.
    typedef enum logic {
        READ_OLD = 1'b0,
        READ_NEW = 1'b1
    } rd_order_e;

endpackage

// File: rtl/rf_wr_decode.sv
// Module rf_wr_decode
// Purpose : turns the write index and enable into one enable per storage row.
//           Row 0 is constant zero, so no enable is produced for it and a
//           write aimed at index 0 reaches no row.
// Assumes : NREG >= 2, IW wide enough to index NREG rows.
module rf_wr_decode #(
    parameter int NREG = 32,
    parameter int IW   = 5
) (
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    output logic [NREG-1:1] row_we
);

    // One comparator per real row; index 0 has none by design.
    for (genvar r = 1; r < NREG; r++) begin : g_row
        assign row_we[r] = wr_en && (wr_idx == IW'(r));
    end

endmodule

// File: rtl/rf_storage.sv
// Module rf_storage
// Purpose : the storage rows. Row 0 is a tied-off constant; rows 1..NREG-1
//           are flops with synchronous active-low clear and a write enable.
// Assumes : at most one row_we bit is high per cycle (guaranteed by decoder).
module rf_storage #(
    parameter int NREG = 32,
    parameter int W    = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NREG-1:1]          row_we,
    input  logic [W-1:0]             wr_data,
    output logic [NREG-1:0][W-1:0]   rows
);

    // Row 0 is not storage: it always presents zero.
    assign rows[0] = '0;

    for (genvar r = 1; r < NREG; r++) begin : g_cell
        logic [W-1:0] q;

        // Clear on reset, otherwise load when this row is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (row_we[r]) begin
                q <= wr_data;
            end
        end

        assign rows[r] = q;
    end

endmodule

// File: rtl/rf_read_port.sv
// Module rf_read_port
// Purpose : one combinational read port. Selects a row by index, or the
//           forwarded write data when fwd_hit is asserted by the parent.
//           Indices at or beyond NREG read as zero.
// Assumes : fwd_hit is only raised for a non-zero index being written.
module rf_read_port #(
    parameter int NREG = 32,
    parameter int W    = 32,
    parameter int IW   = 5
) (
    input  logic [NREG-1:0][W-1:0] rows,
    input  logic [IW-1:0]          rd_idx,
    input  logic                   fwd_hit,
    input  logic [W-1:0]           fwd_data,
    output logic [W-1:0]           rd_data
);

    localparam logic [IW:0] LIMIT = (IW + 1)'(NREG);

    logic [IW:0] idx_ext;
    assign idx_ext = {1'b0, rd_idx};

    // Forwarded data first, then the addressed row, else zero.
    always_comb begin
        if (fwd_hit) begin
            rd_data = fwd_data;
        end else if (idx_ext < LIMIT) begin
            rd_data = rows[rd_idx];
        end else begin
            rd_data = '0;
        end
    end

endmodule

// File: rtl/regfile_3p.sv
// Module regfile_3p
// Purpose : register file with two combinational read ports and one
//           synchronous write port. Index 0 reads zero and ignores writes.
//           RD_ORDER chooses old or forwarded data on a same-cycle
//           read of the register being written.
// Assumes : single clock domain; synchronous active-low reset.
module regfile_3p #(
    parameter int                    NREG     = regfile_pkg::REG_COUNT,
    parameter int                    WORD_W   = regfile_pkg::WORD_BITS,
    parameter regfile_pkg::rd_order_e RD_ORDER = regfile_pkg::READ_OLD,
    localparam int                   IDX_W    = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [WORD_W-1:0] rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [WORD_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data
);

    logic [NREG-1:1]             row_we;
    logic [NREG-1:0][WORD_W-1:0] rows;
    logic                        hit_a;
    logic                        hit_b;

    rf_wr_decode #(.NREG(NREG), .IW(IDX_W)) u_dec (
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .row_we (row_we)
    );

    rf_storage #(.NREG(NREG), .W(WORD_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .row_we  (row_we),
        .wr_data (wr_data),
        .rows    (rows)
    );

    // Forwarding match per read port, present only in the READ_NEW variant.
    if (RD_ORDER == regfile_pkg::READ_NEW) begin : g_fwd
        logic wr_live;
        assign wr_live = rst_n && wr_en && (wr_idx != '0);
        assign hit_a   = wr_live && (wr_idx == rd_a_idx);
        assign hit_b   = wr_live && (wr_idx == rd_b_idx);
    end else begin : g_nofwd
        assign hit_a = 1'b0;
        assign hit_b = 1'b0;
    end

    rf_read_port #(.NREG(NREG), .W(WORD_W), .IW(IDX_W)) u_rd_a (
        .rows     (rows),
        .rd_idx   (rd_a_idx),
        .fwd_hit  (hit_a),
        .fwd_data (wr_data),
        .rd_data  (rd_a_data)
    );

    rf_read_port #(.NREG(NREG), .W(WORD_W), .IW(IDX_W)) u_rd_b (
        .rows     (rows),
        .rd_idx   (rd_b_idx),
        .fwd_hit  (hit_b),
        .fwd_data (wr_data),
        .rd_data  (rd_b_data)
    );

endmodule

// File: rtl/regfile_3p_checker.sv
// Module regfile_3p_checker
// Purpose : port-level properties of regfile_3p, bound into every instance.
// Assumes : observes the top-level ports only.
module regfile_3p_checker #(
    parameter int                     NREG     = 32,
    parameter int                     WORD_W   = 32,
    parameter regfile_pkg::rd_order_e RD_ORDER = regfile_pkg::READ_OLD,
    localparam int                    IDX_W    = $clog2(NREG)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [IDX_W-1:0]  rd_a_idx,
    input logic [WORD_W-1:0] rd_a_data,
    input logic [IDX_W-1:0]  rd_b_idx,
    input logic [WORD_W-1:0] rd_b_data,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [WORD_W-1:0] wr_data
);

    logic fwd_a;
    logic fwd_b;
    assign fwd_a = (RD_ORDER == regfile_pkg::READ_NEW) && rst_n && wr_en &&
                   (wr_idx != '0) && (wr_idx == rd_a_idx);
    assign fwd_b = (RD_ORDER == regfile_pkg::READ_NEW) && rst_n && wr_en &&
                   (wr_idx != '0) && (wr_idx == rd_b_idx);

    // R1: first cycle after reset, every un-forwarded read is zero.
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && !fwd_a) |-> (rd_a_data == '0));

    // R2: a committed write is visible on port A the next cycle.
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && ($past(wr_idx) != '0) &&
         (rd_a_idx == $past(wr_idx)) && !fwd_a)
        |-> (rd_a_data == $past(wr_data)));

    // R3: no enable, same index, no forwarding -> data is stable.
    assert_hold_no_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en) && (rd_b_idx == $past(rd_b_idx)) &&
         !fwd_b && !$past(fwd_b))
        |-> $stable(rd_b_data));

    // R4: index 0 reads zero on both ports.
    assert_zero_read_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == '0) |-> (rd_a_data == '0));
    assert_zero_read_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_idx == '0) |-> (rd_b_data == '0));

    // R5: a write to index 0 leaves the register read on port A unchanged.
    assert_zero_write_inert_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && ($past(wr_idx) == '0) &&
         (rd_a_idx == $past(rd_a_idx)) && !fwd_a && !$past(fwd_a))
        |-> $stable(rd_a_data));

    // R8: in the forwarding variant a same-cycle hit returns the write data.
    assert_forward_new_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_a |-> (rd_a_data == wr_data));

endmodule

bind regfile_3p regfile_3p_checker #(
    .NREG     (NREG),
    .WORD_W   (WORD_W),
    .RD_ORDER (RD_ORDER)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_a_idx  (rd_a_idx),
    .rd_a_data (rd_a_data),
    .rd_b_idx  (rd_b_idx),
    .rd_b_data (rd_b_data),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data)
);

// File: tb/test_regfile_3p.sv
// Scoreboard bench: the driver task pushes expected read values into a
// queue; the monitor drains and compares them just before each rising edge.
module test_regfile_3p;

    localparam time HALF = 10ns;   // 50 MHz
    localparam int  WATCHDOG_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rd_a_idx = '0;
    logic [4:0]  rd_b_idx = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] old_a, old_b, new_a, new_b;

    always #HALF clk = ~clk;

    regfile_3p i_regfile_3p (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(old_a),
        .rd_b_idx(rd_b_idx), .rd_b_data(old_b),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    regfile_3p #(.RD_ORDER(regfile_pkg::READ_NEW)) i_regfile_3p_fwd (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(new_a),
        .rd_b_idx(rd_b_idx), .rd_b_data(new_b),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    typedef struct {
        string       req;
        int          port;     // 0 A old, 1 B old, 2 A fwd, 3 B fwd
        logic [4:0]  idx;
        logic [31:0] exp;
    } item_t;

    item_t       sbq[$];
    logic [31:0] model [32];
    int          compared = 0;
    int          mismatched = 0;
    bit          done = 1'b0;

    // Expected read value for one port, before the coming edge.
    function automatic logic [31:0] expect_rd(bit fwd, bit rn, bit we,
            logic [4:0] wi, logic [31:0] wd, logic [4:0] ri);
        if (fwd && rn && we && wi == ri && ri != 5'd0) return wd;
        return model[ri];
    endfunction

    // Drive one cycle, queue the expected reads, then advance the model.
    task automatic step(input bit rn, input bit we, input logic [4:0] wi,
            input logic [31:0] wd, input logic [4:0] ra, input logic [4:0] rb,
            input bit chk, input string req_a, input string req_b);
        item_t it;
        @(negedge clk);
        #1ns;
        rst_n = rn; wr_en = we; wr_idx = wi; wr_data = wd;
        rd_a_idx = ra; rd_b_idx = rb;
        if (chk) begin
            it.req = req_a; it.port = 0; it.idx = ra; it.exp = expect_rd(0, rn, we, wi, wd, ra); sbq.push_back(it);
            it.req = req_b; it.port = 1; it.idx = rb; it.exp = expect_rd(0, rn, we, wi, wd, rb); sbq.push_back(it);
            it.req = req_a; it.port = 2; it.idx = ra; it.exp = expect_rd(1, rn, we, wi, wd, ra); sbq.push_back(it);
            it.req = req_b; it.port = 3; it.idx = rb; it.exp = expect_rd(1, rn, we, wi, wd, rb); sbq.push_back(it);
        end
        if (!rn) begin
            for (int k = 0; k < 32; k++) model[k] = '0;
        end else if (we && wi != 5'd0) begin
            model[wi] = wd;
        end
    endtask

    // Monitor: compare queued expectations 2 ns before each rising edge.
    initial begin
        forever begin
            @(negedge clk);
            #8ns;
            while (sbq.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sbq.pop_front();
                case (it.port)
                    0:       act = old_a;
                    1:       act = old_b;
                    2:       act = new_a;
                    default: act = new_b;
                endcase
                compared++;
                if (act !== it.exp) begin
                    mismatched++;
                    $display("FAIL %s port%0d idx %0d: actual %h expected %h",
                             it.req, it.port, it.idx, act, it.exp);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 32; k++) model[k] = '0;

        // Reset; storage is undefined until the first edge, so no checks.
        step(0, 0, 0, 0, 0, 0, 0, "R1", "R1");
        step(0, 0, 0, 0, 0, 0, 0, "R1", "R1");

        // R1: every register reads zero after reset.
        for (int i = 0; i < 16; i++)
            step(1, 0, 0, 0, 5'(i), 5'(i + 16), 1, "R1", "R1");

        // R8 on port A (reads the register being written); R4 on port B.
        for (int i = 1; i < 32; i++)
            step(1, 1, 5'(i), 32'hC0DE_0000 | 32'(i * 7 + 1), 5'(i), 5'd0, 1, "R8", "R4");

        // R2, R6, R7: read back all values, two different registers per cycle.
        for (int i = 0; i < 32; i++)
            step(1, 0, 0, 0, 5'(i), 5'(31 - i), 1, "R2", "R6");

        // R3: enable low with live index and data, then read back next cycle.
        for (int i = 1; i < 32; i += 5) begin
            step(1, 0, 5'(i), 32'hDEAD_BEEF, 5'(i), 5'(i), 1, "R3", "R3");
            step(1, 0, 0, 0, 5'(i), 5'(i), 1, "R3", "R3");
        end

        // R5: writes aimed at index 0, then every register read back.
        step(1, 1, 5'd0, 32'hFFFF_FFFF, 5'd0, 5'd1, 1, "R5", "R5");
        step(1, 1, 5'd0, 32'h1234_5678, 5'd0, 5'd0, 1, "R4", "R4");
        for (int i = 0; i < 32; i += 2)
            step(1, 0, 0, 0, 5'(i), 5'(i + 1), 1, "R5", "R7");

        // Random traffic, index 0 favoured as a write target.
        for (int n = 0; n < 3000; n++) begin
            logic [4:0] wi;
            wi = ($urandom % 4 == 0) ? 5'd0 : 5'($urandom);
            step(1, 1'($urandom), wi, $urandom, 5'($urandom), 5'($urandom), 1, "R2", "R7");
        end

        // R1: reset with a write in the same cycle; reset wins.
        step(0, 1, 5'd5, 32'hAAAA_5555, 5'd5, 5'd6, 1, "R1", "R1");
        for (int i = 0; i < 16; i++)
            step(1, 0, 0, 0, 5'(i), 5'(i + 16), 1, "R1", "R1");

        step(1, 0, 0, 0, 0, 0, 0, "", "");
        @(negedge clk);
        #9ns;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule